// File: doc/BRIEF.md
# Periodic Serial ADC Frame Reader

This block sits on the host side of a 16-bit serial analog-to-digital converter that has a three-wire read path (active-low select, serial clock, serial data out). An interval timer triggers equally spaced conversion frames. For each frame the block pulls select low and toggles the serial clock 24 times. The clock's half period comes from a programmable divide value. The block takes the 16 result bits off the data line on rising clock edges and hands the word to the rest of the chip with a one-cycle strobe.

The converter shifts its first frame bit out when select falls, not on a clock edge. Each later bit follows a falling clock edge. The reader captures on rising edges, so it skips the bit driven at select fall and counts rising edges from the first one. A shortened burst of 8 clocks, requested between frames, puts the converter to sleep. The next normal frame wakes it, and that frame's result is discarded. A start that arrives while a transfer is still running is dropped and recorded in a sticky flag.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held and directly after it, `cs_n` and `sclk` are 1 and `result_valid`, `overrun` and `conv_asleep` are 0.
- R2: A normal frame keeps `cs_n` low for exactly 48*D clock cycles and contains 24 falling `sclk` edges. D is `div_val` captured at frame start, and a value of 0 acts as 1.
- R3: `sclk` is 1 whenever `cs_n` is 1. The first `sclk` fall comes D cycles after `cs_n` falls. `cs_n` rises in the same cycle as the final `sclk` rise.
- R4: While `enable` is held high, frames start every I cycles, where I is `ivl_val` (minimum 1). The first frame starts on the first clock edge at which `enable` is sampled high. Dropping `enable` restarts this phase.
- R5: Frame bit 1 is driven at `cs_n` fall and frame bit n+1 is present at rising `sclk` edge n. `result` is frame bits 5 to 20, taken on rising edges 4 to 19, MSB first. Bits 1 to 4 and 21 to 24 are ignored whatever their values.
- R6: `result_valid` is a one-cycle pulse in the cycle `cs_n` rises at the end of a normal, non-wake frame, and `result` holds the new word in that cycle.
- R7: Changing `div_val` during a frame does not alter that frame. `ivl_val` is captured at each frame start, so a change during a frame first affects the spacing after the next start.
- R8: A timer expiry while a transfer is active starts nothing and sets `overrun`. `overrun` stays set until a cycle with `ovr_clr` high and no new expiry.
- R9: A `pd_req` pulse while idle, with no timer expiry in that cycle, produces a burst of 8 falling `sclk` edges with `cs_n` low for 16*D cycles. This burst raises no `result_valid` and leaves `conv_asleep` at 1.
- R10: A `pd_req` pulse while a frame is active is ignored: no burst follows and `conv_asleep` stays 0.
- R11: The first normal frame after a power-down burst clears `conv_asleep` at its start, runs the full 24 clocks and raises no `result_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the interval timer |
| div_val | input | DIV_W (8) | Serial clock half period, in clock cycles |
| ivl_val | input | IVL_W (16) | Frame spacing, in clock cycles |
| pd_req | input | 1 | Request a power-down burst |
| ovr_clr | input | 1 | Clear the overrun flag |
| sdata_in | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| result | output | RES_W (16) | Last extracted conversion word |
| result_valid | output | 1 | One-cycle strobe for a new result |
| overrun | output | 1 | Sticky flag for a dropped frame start |
| conv_asleep | output | 1 | Converter has been sent to power-down |

## Verification
The assertions assume that `rst_n` is asserted at time zero. They also assume that `pd_req` and `ovr_clr` are driven synchronously, away from the clock edge. The bench changes every input on the falling clock edge. The data model shifts a new bit only on `cs_n` fall and on `sclk` fall, as a real converter would. The bench fills the pad bits with ones, so a capture window that is off by one edge produces a wrong word. It keeps the interval larger than the frame, except in the overrun test, which deliberately makes the interval shorter.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  // Half period in clock cycles; a zero divide value behaves as one.
  function automatic int eff_div(input int d);
    return (d < 1) ? 1 : d;
  endfunction

  // Number of half periods in a frame of n serial clocks.
  function automatic int half_periods(input int n);
    return 2 * n;
  endfunction

  // True when rising edge idx carries a result bit.
  function automatic bit in_window(input int idx, input int lead, input int width);
    return (idx >= lead) && (idx < lead + width);
  endfunction
endpackage

// File: rtl/adc_interval_timer.sv
module adc_interval_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [IVL_W-1:0] ivl_val,
  output logic             tick
);
  logic [IVL_W-1:0] cnt;

  assign tick = enable && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (tick)    cnt <= (ivl_val == '0) ? '0 : ivl_val - 1'b1;
    else              cnt <= cnt - 1'b1;
  end

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ivl_val > 1) |=> !tick);
endmodule

// File: rtl/adc_serial_engine.sv
module adc_serial_engine
  import adc_frame_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int FRAME_N  = 24,
  parameter int PD_N     = 8,
  localparam int PH_W    = $clog2(2 * FRAME_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pd_req,
  input  logic             ovr_clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             rise_evt,
  output logic [PH_W-1:0]  rise_idx,
  output logic             done_evt,
  output logic             kind_pd,
  output logic             wake_frm,
  output logic             overrun,
  output logic             asleep
);
  localparam logic [PH_W-1:0] LAST_NORM = PH_W'(half_periods(FRAME_N));
  localparam logic [PH_W-1:0] LAST_PD   = PH_W'(half_periods(PD_N));

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] hc;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  ph_nxt;
  logic [PH_W-1:0]  ph_last;
  logic             adv;
  logic             start_norm;
  logic             start_pd;

  assign busy       = !cs_n;
  assign adv        = busy && (hc == '0);
  assign ph_nxt     = ph + 1'b1;
  assign ph_last    = kind_pd ? LAST_PD : LAST_NORM;
  assign rise_evt   = adv && !ph_nxt[0];
  assign rise_idx   = ph_nxt >> 1;
  assign done_evt   = adv && (ph_nxt == ph_last);
  assign start_norm = !busy && tick;
  assign start_pd   = !busy && !tick && pd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n    <= 1'b1;
      sclk    <= 1'b1;
      div_q   <= '0;
      hc      <= '0;
      ph      <= '0;
      kind_pd <= 1'b0;
    end else if (start_norm || start_pd) begin
      cs_n    <= 1'b0;
      sclk    <= 1'b1;
      div_q   <= DIV_W'(eff_div(int'(div_val)));
      hc      <= DIV_W'(eff_div(int'(div_val)) - 1);
      ph      <= '0;
      kind_pd <= start_pd;
    end else if (adv) begin
      hc   <= div_q - 1'b1;
      ph   <= ph_nxt;
      sclk <= !ph_nxt[0];
      if (done_evt) cs_n <= 1'b1;
    end else if (busy) begin
      hc <= hc - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun  <= 1'b0;
      asleep   <= 1'b0;
      wake_frm <= 1'b0;
    end else begin
      if (tick && busy) overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
      if (start_norm) begin
        wake_frm <= asleep;
        asleep   <= 1'b0;
      end else if (done_evt && kind_pd) begin
        asleep <= 1'b1;
      end
    end
  end

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_end_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk && !$past(sclk)));
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph <= ph_last));
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy) |=> overrun);
  assert_pd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !kind_pd && !done_evt) |=> !kind_pd);
endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture
  import adc_frame_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int LEAD  = 4,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata_in,
  input  logic             rise_evt,
  input  logic [PH_W-1:0]  rise_idx,
  input  logic             done_evt,
  input  logic             kind_pd,
  input  logic             wake_frm,
  output logic [RES_W-1:0] result,
  output logic             result_valid
);
  logic [RES_W-1:0] shreg;
  logic             take;

  assign take = rise_evt && in_window(int'(rise_idx), LEAD, RES_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      if (take) shreg <= {shreg[RES_W-2:0], sdata_in};
      result_valid <= done_evt && !kind_pd && !wake_frm;
      if (done_evt && !kind_pd && !wake_frm) result <= shreg;
    end
  end

  assert_no_pd_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && kind_pd) |=> !result_valid);
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W   = 8,
  parameter int IVL_W   = 16,
  parameter int RES_W   = 16,
  parameter int FRAME_N = 24,
  parameter int PD_N    = 8,
  parameter int LEAD    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_val,
  input  logic [IVL_W-1:0] ivl_val,
  input  logic             pd_req,
  input  logic             ovr_clr,
  input  logic             sdata_in,
  output logic             sclk,
  output logic             cs_n,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             overrun,
  output logic             conv_asleep
);
  localparam int PH_W = $clog2(2 * FRAME_N + 1);

  logic            tick;
  logic            busy;
  logic            rise_evt;
  logic [PH_W-1:0] rise_idx;
  logic            done_evt;
  logic            kind_pd;
  logic            wake_frm;

  adc_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ivl_val(ivl_val), .tick(tick)
  );

  adc_serial_engine #(.DIV_W(DIV_W), .FRAME_N(FRAME_N), .PD_N(PD_N)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pd_req(pd_req), .ovr_clr(ovr_clr),
    .div_val(div_val), .sclk(sclk), .cs_n(cs_n), .busy(busy),
    .rise_evt(rise_evt), .rise_idx(rise_idx), .done_evt(done_evt),
    .kind_pd(kind_pd), .wake_frm(wake_frm), .overrun(overrun), .asleep(conv_asleep)
  );

  adc_bit_capture #(.RES_W(RES_W), .LEAD(LEAD), .PH_W(PH_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in), .rise_evt(rise_evt),
    .rise_idx(rise_idx), .done_evt(done_evt), .kind_pd(kind_pd),
    .wake_frm(wake_frm), .result(result), .result_valid(result_valid)
  );

  assert_valid_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && $past(!cs_n)));
  assert_asleep_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_asleep) |-> (cs_n && !busy));
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  div_val = 8'd1;
  logic [15:0] ivl_val = 16'd200;
  logic        pd_req = 1'b0;
  logic        ovr_clr = 1'b0;
  logic        sdata_in = 1'b1;
  logic        sclk, cs_n, result_valid, overrun, conv_asleep;
  logic [15:0] result;

  int tests = 0, fails = 0;
  int cyc = 0, starts = 0, dones = 0, valids = 0;
  int lowcnt = 0, falls = 0, first_dly = 0, last_len = 0, last_falls = 0;
  int t_start = 0, t_prev = 0;
  int mk = 0, bitn = 0;
  logic [15:0] cur_word = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;

  adc_frame_reader u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
    .ivl_val(ivl_val), .pd_req(pd_req), .ovr_clr(ovr_clr), .sdata_in(sdata_in),
    .sclk(sclk), .cs_n(cs_n), .result(result), .result_valid(result_valid),
    .overrun(overrun), .conv_asleep(conv_asleep)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] word_of(input int k);
    return 16'hB4E1 ^ 16'(k * 32'h2F3D) ^ 16'(k << 3);
  endfunction

  // Pad bits are driven as ones so a misplaced window shows up.
  function automatic logic frame_bit(input int b, input logic [15:0] w);
    if (b >= 5 && b <= 20) return w[20 - b];
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter model: bit 1 at select fall, next bit after each clock fall.
  always @(negedge cs_n) begin
    mk++;
    cur_word = word_of(mk);
    bitn = 1;
    sdata_in <= frame_bit(1, cur_word);
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      bitn++;
      sdata_in <= frame_bit(bitn, cur_word);
    end
  end

  // Monitor, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      starts++; lowcnt = 0; falls = 0; first_dly = 0;
      t_prev = t_start; t_start = cyc;
    end
    if (!cs_n) lowcnt++;
    if (prev_sclk && !sclk && !cs_n) begin
      falls++;
      if (falls == 1) first_dly = cyc - t_start;
    end
    if (!cs_n && !sclk) chk(1'b1, "R3", 0, 0);
    if (cs_n && !sclk) chk(1'b0, "R3 sclk low while idle", 0, 1);
    if (!prev_cs && cs_n) begin
      dones++; last_len = lowcnt; last_falls = falls;
    end
    if (result_valid) begin
      valids++;
      chk(result == cur_word, "R5 result word", int'(result), int'(cur_word));
      chk(!prev_cs && cs_n, "R6 valid at select rise", int'(cs_n), 1);
      chk(!prev_valid, "R6 single-cycle strobe", 1, 0);
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_valid = result_valid;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_one;
    @(negedge clk); enable = 1'b1;
    @(negedge clk); enable = 1'b0;
  endtask

  task automatic pulse_pd;
    @(negedge clk); pd_req = 1'b1;
    @(negedge clk); pd_req = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int v0;
    int s0;
    wait_cycles(3);
    chk(cs_n && sclk && !result_valid && !overrun && !conv_asleep,
        "R1 in reset", int'({cs_n, sclk, result_valid, overrun, conv_asleep}), 5'b11000);
    rst_n = 1'b1;
    wait_cycles(2);
    chk(cs_n && sclk && !result_valid && !overrun && !conv_asleep,
        "R1 after reset", int'({cs_n, sclk, result_valid, overrun, conv_asleep}), 5'b11000);

    // R2/R3/R5/R6 sweep over divide values, D=0 acts as 1.
    for (int d = 0; d <= 4; d++) begin
      for (int r = 0; r < 3; r++) begin
        int de;
        de = (d < 1) ? 1 : d;
        div_val = 8'(d);
        v0 = valids;
        start_one();
        wait_cycles(48 * de + 4);
        chk(last_len == 48 * de, "R2 frame length", last_len, 48 * de);
        chk(last_falls == 24, "R2 clock count", last_falls, 24);
        chk(first_dly == de, "R3 first fall delay", first_dly, de);
        chk(valids == v0 + 1, "R6 one strobe per frame", valids - v0, 1);
      end
    end

    // R4 and R7: spacing follows the interval captured at each start.
    div_val = 8'd2; ivl_val = 16'd150;
    s0 = starts;
    @(negedge clk); enable = 1'b1;
    wait (starts == s0 + 1);
    wait_cycles(10);
    div_val = 8'd3; ivl_val = 16'd180;
    wait (starts == s0 + 2);
    chk(t_start - t_prev == 150, "R4 spacing", t_start - t_prev, 150);
    chk(last_len == 96, "R7 divide held mid-frame", last_len, 96);
    wait (starts == s0 + 3);
    chk(t_start - t_prev == 180, "R7 interval taken at start", t_start - t_prev, 180);
    chk(dones == s0 + 2 && last_len == 144, "R7 new divide next frame", last_len, 144);
    enable = 1'b0;
    wait_cycles(160);

    // R8: interval shorter than the frame.
    div_val = 8'd1; ivl_val = 16'd20;
    chk(!overrun, "R8 flag clear before", int'(overrun), 0);
    s0 = starts;
    @(negedge clk); enable = 1'b1;
    wait_cycles(70);
    enable = 1'b0;
    wait_cycles(120);
    chk(starts == s0 + 2, "R8 starts dropped", starts - s0, 2);
    chk(overrun, "R8 sticky flag", int'(overrun), 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(!overrun, "R8 clear", int'(overrun), 0);

    // R9: power-down burst while idle.
    div_val = 8'd2; ivl_val = 16'd200;
    v0 = valids;
    pulse_pd();
    wait_cycles(40);
    chk(last_len == 32, "R9 burst length", last_len, 32);
    chk(last_falls == 8, "R9 burst clocks", last_falls, 8);
    chk(valids == v0, "R9 no strobe", valids - v0, 0);
    chk(conv_asleep, "R9 asleep", int'(conv_asleep), 1);

    // R11: wake frame.
    start_one();
    wait_cycles(2);
    chk(!conv_asleep, "R11 asleep cleared at start", int'(conv_asleep), 0);
    wait_cycles(100);
    chk(last_len == 96 && last_falls == 24, "R11 full wake frame", last_falls, 24);
    chk(valids == v0, "R11 wake result discarded", valids - v0, 0);

    // R10: power-down request during a frame.
    s0 = starts;
    start_one();
    wait_cycles(20);
    pulse_pd();
    wait_cycles(120);
    chk(starts == s0 + 1, "R10 no burst after frame", starts - s0, 1);
    chk(!conv_asleep, "R10 still awake", int'(conv_asleep), 0);
    chk(valids == v0 + 1, "R10 frame still valid", valids - v0, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule